// File: doc/BRIEF.md
# Address-Threshold Write Protect Unit

This block decides, for every single-word write, single-word erase and bulk write that a serial front end decodes, whether the programming sequencer may go ahead (grant) or must drop the request (abort). It keeps a protect threshold address. When the threshold is set, any target whose effective address is equal to or above it is refused. In the cleared state, nothing is refused on address grounds. A bulk write needs the threshold to be cleared, because it would touch protected words.

The threshold is managed by a small protect command set: show, arm, set, wipe and freeze. A dedicated protect pin qualifies these commands. Set, wipe and freeze also need an earlier arm command in the same session. Freeze is a one-time lock, modelled as a sticky bit. After freeze, the threshold can no longer change, and only the power-on reset clears the lock. The soft reset clears the arm flag and the output pulses. It keeps the threshold, its set flag and the lock.

Commands arrive on a valid/ready interface. `cmd_ready` is always high, so the block never applies back-pressure: every cycle with `cmd_valid` high accepts one command. The sequencer cannot stall results, so verdicts and readbacks are single-cycle pulses.

Top module: `wp_guard`

## Requirements
- R1: With the threshold set and the protect pin low, a write or erase whose effective address is below the threshold is granted. One whose effective address is at or above the threshold is aborted.
- R2: With the threshold cleared and the protect pin low, every write and erase is granted.
- R3: A write, erase or bulk write issued while the protect pin is high is aborted.
- R4: A bulk write is granted only when the threshold is cleared and the protect pin is low. Otherwise it is aborted.
- R5: An arm command with the protect pin high sets the arm flag. Set, wipe and freeze are ignored unless the arm flag is set and the protect pin is high.
- R6: An accepted set stores `cmd_addr` as the threshold and marks it set. An accepted wipe marks it cleared and leaves the stored value as it was.
- R7: An accepted freeze locks the unit. Once it is locked, set, wipe and freeze have no effect. The lock survives the soft reset and is cleared only by `por_n`.
- R8: The comparison uses only the low ARRAY_AW bits (default 7) of the address and of the threshold. Readback returns all THR_W bits (default 8) as stored.
- R9: A show command with the protect pin high gives `rd_valid` for one cycle, with the stored threshold on `rd_thr` and its set flag on `rd_set`. A show with the pin low gives nothing.
- R10: Opcodes are 1 write, 2 erase, 3 bulk write, 8 show, 9 arm, 10 wipe, 11 set and 12 freeze. Every other value is ignored. `cmd_ready` is always 1. The verdict for an accepted program command appears on the cycle after acceptance: `res_valid` is high for one cycle, with exactly one of `res_grant` and `res_abort` high. The verdict uses the state from before that edge.
- R11: The soft reset `rst_n` clears the arm flag and both output pulses. It keeps the threshold value, the set flag and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears all state including the lock |
| rst_n | input | 1 | Soft reset, active low; clears the arm flag and output pulses |
| prot_pin | input | 1 | Protect-enable pin, high to qualify protect commands |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always 1 |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | THR_W | Target address or new threshold |
| res_valid | output | 1 | Verdict pulse for a program command |
| res_grant | output | 1 | Request allowed |
| res_abort | output | 1 | Request refused |
| rd_valid | output | 1 | Threshold readback pulse |
| rd_thr | output | THR_W | Stored threshold value |
| rd_set | output | 1 | Threshold set flag |

## Verification
A corrupted threshold or set flag stays hidden until the next program command or show. Its first port-level sign is a wrong grant/abort, or a wrong readback, one cycle after that command. A lost arm flag or a missing lock shows up only later, when a set or wipe wrongly does or does not change what the next show returns. For that reason the bench follows every state-changing command with readbacks and with program requests on both sides of the threshold. It also checks that the top address bit, which the compare ignores, changes no verdict.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_WRITE  = 4'd1,
    OP_ERASE  = 4'd2,
    OP_BULK   = 4'd3,
    OP_SHOW   = 4'd8,
    OP_ARM    = 4'd9,
    OP_WIPE   = 4'd10,
    OP_SET    = 4'd11,
    OP_FREEZE = 4'd12
  } wp_op_e;

  typedef struct packed {
    logic prog;
    logic bulk;
    logic show;
    logic arm;
    logic set;
    logic wipe;
    logic freeze;
  } wp_strobe_t;
endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
  import wp_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [3:0] cmd_op,
  input  logic       prot_pin,
  input  logic       armed,
  input  logic       locked,
  output wp_strobe_t stb
);
  logic pin_ok;
  logic change_ok;

  always_comb begin
    pin_ok    = cmd_valid && prot_pin;
    change_ok = pin_ok && armed && !locked;
    stb = '0;
    case (cmd_op)
      OP_WRITE, OP_ERASE: stb.prog = cmd_valid;
      OP_BULK:   begin stb.prog = cmd_valid; stb.bulk = cmd_valid; end
      OP_SHOW:   stb.show   = pin_ok;
      OP_ARM:    stb.arm    = pin_ok;
      OP_SET:    stb.set    = change_ok;
      OP_WIPE:   stb.wipe   = change_ok;
      OP_FREEZE: stb.freeze = change_ok;
      default:   stb = '0;
    endcase
  end
endmodule

// File: rtl/wp_thr_reg.sv
module wp_thr_reg #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             do_arm,
  input  logic             do_set,
  input  logic             do_wipe,
  input  logic             do_freeze,
  input  logic [THR_W-1:0] new_thr,
  output logic [THR_W-1:0] thr,
  output logic             thr_set,
  output logic             locked,
  output logic             armed
);
  // Persistent state: only power-on clears it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      thr     <= '0;
      thr_set <= 1'b0;
      locked  <= 1'b0;
    end else begin
      if (do_set) begin
        thr     <= new_thr;
        thr_set <= 1'b1;
      end else if (do_wipe) begin
        thr_set <= 1'b0;
      end
      if (do_freeze) locked <= 1'b1;
    end
  end

  // Session state: either reset clears it.
  always_ff @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n || !rst_n) armed <= 1'b0;
    else if (do_arm)      armed <= 1'b1;
  end
endmodule

// File: rtl/wp_cmp.sv
module wp_cmp #(
  parameter int THR_W    = 8,
  parameter int ARRAY_AW = 7
) (
  input  logic [THR_W-1:0] addr,
  input  logic [THR_W-1:0] thr,
  input  logic             thr_set,
  output logic             in_zone
);
  logic [THR_W-1:0] mask;

  generate
    if (ARRAY_AW >= THR_W) begin : g_full
      assign mask = '1;
    end else begin : g_part
      assign mask = {{(THR_W-ARRAY_AW){1'b0}}, {ARRAY_AW{1'b1}}};
    end
  endgenerate

  assign in_zone = thr_set && ((addr & mask) >= (thr & mask));
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int THR_W    = 8,
  parameter int ARRAY_AW = 7
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             prot_pin,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_op,
  input  logic [THR_W-1:0] cmd_addr,
  output logic             res_valid,
  output logic             res_grant,
  output logic             res_abort,
  output logic             rd_valid,
  output logic [THR_W-1:0] rd_thr,
  output logic             rd_set
);
  wp_strobe_t       stb;
  logic [THR_W-1:0] thr;
  logic             thr_set;
  logic             locked;
  logic             armed;
  logic             in_zone;
  logic             allow;

  assign cmd_ready = 1'b1;

  wp_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .prot_pin  (prot_pin),
    .armed     (armed),
    .locked    (locked),
    .stb       (stb)
  );

  wp_thr_reg #(.THR_W(THR_W)) u_reg (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .do_arm    (stb.arm),
    .do_set    (stb.set),
    .do_wipe   (stb.wipe),
    .do_freeze (stb.freeze),
    .new_thr   (cmd_addr),
    .thr       (thr),
    .thr_set   (thr_set),
    .locked    (locked),
    .armed     (armed)
  );

  wp_cmp #(.THR_W(THR_W), .ARRAY_AW(ARRAY_AW)) u_cmp (
    .addr    (cmd_addr),
    .thr     (thr),
    .thr_set (thr_set),
    .in_zone (in_zone)
  );

  always_comb begin
    if (prot_pin)      allow = 1'b0;
    else if (stb.bulk) allow = !thr_set;
    else               allow = !in_zone;
  end

  always_ff @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n || !rst_n) begin
      res_valid <= 1'b0;
      res_grant <= 1'b0;
      res_abort <= 1'b0;
      rd_valid  <= 1'b0;
      rd_thr    <= '0;
      rd_set    <= 1'b0;
    end else begin
      res_valid <= stb.prog;
      res_grant <= stb.prog && allow;
      res_abort <= stb.prog && !allow;
      rd_valid  <= stb.show;
      if (stb.show) begin
        rd_thr <= thr;
        rd_set <= thr_set;
      end
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             prot_pin,
  input logic             cmd_valid,
  input logic             res_valid,
  input logic             res_grant,
  input logic             res_abort,
  input logic             rd_valid,
  input logic [THR_W-1:0] thr,
  input logic             thr_set,
  input logic             locked,
  input logic             armed
);
  // R10: a verdict carries exactly one of grant or abort
  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    res_valid |-> (res_grant ^ res_abort));

  // R10: verdict and readback pulses never coincide
  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $onehot0({res_valid, rd_valid}));

  // R3: a grant needs the protect pin low when the command was taken
  p_pin_blocks_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    res_grant |-> $past(!prot_pin && cmd_valid));

  // R7: once locked, stays locked
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> locked);

  // R7: a locked threshold never moves
  p_lock_freezes_r7: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> ($stable(thr) && $stable(thr_set)));

  // R5: threshold changes only while armed
  p_need_arm_r5: assert property (@(posedge clk) disable iff (!por_n)
    !armed |=> ($stable(thr) && $stable(thr_set)));
endmodule

bind wp_guard wp_guard_chk #(.THR_W(THR_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_n     (rst_n),
  .prot_pin  (prot_pin),
  .cmd_valid (cmd_valid),
  .res_valid (res_valid),
  .res_grant (res_grant),
  .res_abort (res_abort),
  .rd_valid  (rd_valid),
  .thr       (thr),
  .thr_set   (thr_set),
  .locked    (locked),
  .armed     (armed)
);

// File: tb/tb_wp_guard.sv
module tb_wp_guard;
  localparam int THR_W = 8;
  localparam int AAW   = 7;

  logic clk = 1'b0;
  logic por_n, rst_n, prot_pin, cmd_valid, cmd_ready;
  logic [3:0] cmd_op;
  logic [THR_W-1:0] cmd_addr;
  logic res_valid, res_grant, res_abort, rd_valid, rd_set;
  logic [THR_W-1:0] rd_thr;

  int checks = 0;
  int errors = 0;
  int m_thr = 0;
  bit m_set = 0, m_lock = 0, m_arm = 0;
  bit e_rv = 0, e_gr = 0, e_ab = 0, e_dv = 0, e_ds = 0;
  int e_dt = 0;

  always #5 clk = ~clk;

  wp_guard #(.THR_W(THR_W), .ARRAY_AW(AAW)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .prot_pin(prot_pin),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .res_valid(res_valid), .res_grant(res_grant),
    .res_abort(res_abort), .rd_valid(rd_valid), .rd_thr(rd_thr), .rd_set(rd_set)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    chk({req, " cmd_ready"}, cmd_ready, 1);
    chk({req, " res_valid"}, res_valid, e_rv);
    chk({req, " res_grant"}, res_grant, e_gr);
    chk({req, " res_abort"}, res_abort, e_ab);
    chk({req, " rd_valid"}, rd_valid, e_dv);
    if (e_dv) begin
      chk({req, " rd_thr"}, rd_thr, e_dt);
      chk({req, " rd_set"}, rd_set, e_ds);
    end
  endtask

  // Behavioural reference: verdict from pre-edge state, then update.
  task automatic model(input int op, input int a, input bit pin);
    bit zone;
    zone = m_set && ((a % (1 << AAW)) >= (m_thr % (1 << AAW)));
    e_rv = 0; e_gr = 0; e_ab = 0; e_dv = 0;
    case (op)
      1, 2: begin e_rv = 1; e_gr = !pin && !zone; end
      3:    begin e_rv = 1; e_gr = !pin && !m_set; end
      8:    if (pin) begin e_dv = 1; e_dt = m_thr; e_ds = m_set; end
      9:    if (pin) m_arm = 1;
      10:   if (pin && m_arm && !m_lock) m_set = 0;
      11:   if (pin && m_arm && !m_lock) begin m_thr = a; m_set = 1; end
      12:   if (pin && m_arm && !m_lock) m_lock = 1;
      default: ;
    endcase
    e_ab = e_rv && !e_gr;
  endtask

  // Drives at negedge, compares at the following negedge.
  task automatic cmd(input string req, input int op, input int a, input bit pin);
    cmd_valid = 1; cmd_op = 4'(op); cmd_addr = THR_W'(a); prot_pin = pin;
    model(op, a, pin);
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
    compare_all(req);
  endtask

  task automatic idle(input string req);
    cmd_valid = 0;
    e_rv = 0; e_gr = 0; e_ab = 0; e_dv = 0;
    @(posedge clk); @(negedge clk);
    compare_all(req);
  endtask

  task automatic soft_reset();
    rst_n = 0; m_arm = 0; e_rv = 0; e_gr = 0; e_ab = 0; e_dv = 0;
    @(negedge clk);
    compare_all("R11 in soft reset");
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic power_reset();
    por_n = 0; m_arm = 0; m_set = 0; m_lock = 0; m_thr = 0;
    e_rv = 0; e_gr = 0; e_ab = 0; e_dv = 0;
    @(negedge clk);
    compare_all("R7 in power reset");
    por_n = 1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    por_n = 0; rst_n = 0; prot_pin = 0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0;
    repeat (3) @(negedge clk);
    compare_all("R11 reset state");
    por_n = 1; rst_n = 1;
    @(negedge clk);

    // R2: cleared threshold grants everything
    cmd("R2 write no thr", 1, 200, 0);
    cmd("R2 erase no thr", 2, 0, 0);
    cmd("R4 bulk cleared", 3, 0, 0);
    cmd("R3 write pin high", 1, 5, 1);
    cmd("R3 bulk pin high", 3, 5, 1);
    cmd("R10 unknown op", 5, 5, 0);
    cmd("R10 nop", 0, 5, 1);
    idle("R10 idle");

    // R5: set without arm is ignored
    cmd("R5 set unarmed", 11, 40, 1);
    cmd("R9 show", 8, 0, 1);
    cmd("R9 show pin low", 8, 0, 0);
    cmd("R5 arm pin low", 9, 0, 0);
    cmd("R5 set still unarmed", 11, 40, 1);
    cmd("R9 show after", 8, 0, 1);
    cmd("R5 arm", 9, 0, 1);
    cmd("R5 set pin low", 11, 41, 0);
    cmd("R6 set", 11, 40, 1);
    cmd("R6 show set", 8, 0, 1);

    // R1 boundaries and R8 top-bit masking
    cmd("R1 below", 1, 39, 0);
    cmd("R1 equal", 1, 40, 0);
    cmd("R1 above", 2, 41, 0);
    cmd("R1 erase below", 2, 0, 0);
    cmd("R8 masked top bit below", 1, 128 + 39, 0);
    cmd("R8 masked top bit equal", 2, 128 + 40, 0);
    cmd("R4 bulk with thr", 3, 0, 0);

    cmd("R6 set high bit", 11, 128 + 10, 1);
    cmd("R8 readback full", 8, 0, 1);
    cmd("R8 cmp low bits below", 1, 9, 0);
    cmd("R8 cmp low bits at", 1, 10, 0);
    cmd("R8 cmp addr 127", 2, 127, 0);

    // R6: wipe keeps value, clears flag
    cmd("R6 wipe", 10, 0, 1);
    cmd("R6 show wiped", 8, 0, 1);
    cmd("R2 write after wipe", 1, 127, 0);
    cmd("R4 bulk after wipe", 3, 0, 0);

    // R11: soft reset drops arm, keeps threshold
    cmd("R6 set again", 11, 64, 1);
    soft_reset();
    cmd("R11 show kept", 8, 0, 1);
    cmd("R11 set after soft reset", 11, 3, 1);
    cmd("R11 show unchanged", 8, 0, 1);
    cmd("R1 after soft reset", 1, 64, 0);

    // R7: freeze
    cmd("R7 arm", 9, 0, 1);
    cmd("R7 freeze", 12, 0, 1);
    cmd("R7 set locked", 11, 5, 1);
    cmd("R7 wipe locked", 10, 0, 1);
    cmd("R7 show locked", 8, 0, 1);
    soft_reset();
    cmd("R7 arm after soft", 9, 0, 1);
    cmd("R7 wipe after soft", 10, 0, 1);
    cmd("R7 show still locked", 8, 0, 1);
    cmd("R7 write locked zone", 1, 63, 0);
    cmd("R7 write locked above", 1, 100, 0);
    power_reset();
    cmd("R7 show after por", 8, 0, 1);
    cmd("R7 arm after por", 9, 0, 1);
    cmd("R7 set after por", 11, 20, 1);
    cmd("R7 show new", 8, 0, 1);
    cmd("R1 new thr above", 1, 20, 0);
    cmd("R1 new thr below", 2, 19, 0);

    // back-to-back mixed traffic
    for (int i = 0; i < 40; i++) begin
      cmd("R10 stream", (i % 3) + 1, (i * 37) % 256, (i % 7) == 0);
    end
    idle("R10 final idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule